// File: doc/BRIEF.md
# Four-Phase Fractional Duration Sequencer

This block sequences the four switching phases of an inductive power stage. Each phase owns one switch output, and the phases are visited in a fixed rotation: 0, 1, 2, 3, then back to 0. Every phase length is supplied as an unsigned fixed-point number of clock periods, with an integer part and a fractional part. At its intended 200 MHz clock, one period is 5 ns, and the block cannot place an edge inside a period. It therefore realises a fraction such as 13.725 periods by dithering. A first-order residue accumulator, one per phase, lengthens the phase by one clock in some switching cycles. Over many cycles the mean length converges on the programmed value.

A controller raises `run_en` to start cycling from phase 0. All four lengths are sampled together at the start of every switching cycle, so the loop driving the stage can change them from one cycle to the next. A one-clock `cycle_start_o` pulse marks each sampling instant. Dropping `run_en` lets the current switching cycle run to its end, after which the block rests idle with every switch open.

Top module: `quad_phase_dither_seq`

## Requirements
- R1: A synchronous active-high `rst` drives every switch output and `cycle_start_o` low on the next edge and clears all residue accumulators. The first cycle after reset therefore uses an accumulator value of 0 for every phase.
- R2: At most one bit of `sw_o` is high on any clock.
- R3: Within a switching cycle, phases run in ascending index order 0, 1, 2, 3 with no idle clock between them or between consecutive cycles. Bit p of `sw_o` stays high for exactly the effective count of phase p.
- R4: Phase p's length is `dur_i[p*18 +: 18]`, with bits [17:10] as the integer part and bits [9:0] as the fraction in units of 1/1024. At each cycle start the fraction is added to that phase's 10-bit accumulator. The effective count is the integer plus the carry out of that addition, and the accumulator keeps the low 10 bits of the sum.
- R5: Lengths are sampled only at the clock that raises `cycle_start_o`. Changes to `dur_i` during a cycle do not affect that cycle.
- R6: `cycle_start_o` is a one-clock pulse at each sampling of new lengths. Every pulse occurs when a cycle begins.
- R7: A phase whose effective count is zero takes no clock and its switch output is not asserted. Its accumulator still advances.
- R8: When `run_en` is high while idle, the first cycle starts on that clock at the lowest phase with a nonzero count. When `run_en` is low at the end of a cycle, the block goes idle and all outputs stay low.
- R9: After reset, over N complete cycles with a constant length I + F/1024, the total high time of that phase equals N*I + floor(N*F/1024) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Start cycling / allow another cycle |
| dur_i | input | 72 | Four 18-bit fixed-point phase lengths, phase p at bits p*18 +: 18 |
| sw_o | output | 4 | Registered switch drive, one bit per phase |
| cycle_start_o | output | 1 | One-clock pulse when new lengths are sampled |

## Verification
The embedded assertions check these properties on every clock:
- at most one switch is closed;
- the phase index only rises inside a cycle;
- a cycle starts only when the previous phase has finished or the block is idle;
- the sampled lengths hold steady between cycle starts;
- the accumulator wraps exactly when a phase is lengthened;
- the outputs are low during and after reset and while idle.

Exact phase lengths, how zero-length phases are skipped, the point at which an idle request takes effect, and the long-run mean of a dithered length can only be shown by the bench. The bench compares against a queue-based reference model on every clock and measures pulse widths across directed and randomised length sequences.

// File: rtl/qpd_pkg.sv
package qpd_pkg;
   localparam int QPD_PHASES = 4;
   localparam int QPD_INT_W  = 8;
   localparam int QPD_FRAC_W = 10;
endpackage

// File: rtl/qpd_frac_acc.sv
module qpd_frac_acc #(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_i,
   input  logic [INT_W-1:0] int_i,
   input  logic [FRAC_W-1:0] frac_i,
   output logic [INT_W:0]   eff_o
);
   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W:0]   sum;

   assign sum   = {1'b0, acc_q} + {1'b0, frac_i};
   assign eff_o = {1'b0, int_i} + {{INT_W{1'b0}}, sum[FRAC_W]};

   always_ff @(posedge clk) begin
      if (rst)         acc_q <= '0;
      else if (step_i) acc_q <= sum[FRAC_W-1:0];
   end

   // R4
   acc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      step_i |=> ((acc_q < $past(acc_q)) == ($past(eff_o) != {1'b0, $past(int_i)})));
endmodule

// File: rtl/qpd_phase_pick.sv
module qpd_phase_pick #(
   parameter int NUM_PHASES = 4,
   parameter int IDX_W      = 2
) (
   input  logic [NUM_PHASES-1:0] mask_i,
   input  logic [IDX_W:0]        start_i,
   output logic                  found_o,
   output logic [IDX_W-1:0]      idx_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = NUM_PHASES - 1; i >= 0; i--) begin
         if (mask_i[i] && (i >= int'(start_i))) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/qpd_down_cnt.sv
module qpd_down_cnt #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic [W-1:0] cnt_o
);
   always_ff @(posedge clk) begin
      if (rst)               cnt_o <= '0;
      else if (load_i)       cnt_o <= val_i;
      else if (cnt_o != '0)  cnt_o <= cnt_o - W'(1);
   end
endmodule

// File: rtl/quad_phase_dither_seq.sv
module quad_phase_dither_seq
   import qpd_pkg::*;
#(
   parameter int NUM_PHASES = QPD_PHASES,
   parameter int INT_W      = QPD_INT_W,
   parameter int FRAC_W     = QPD_FRAC_W
) (
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic                                  run_en,
   input  logic [NUM_PHASES*(INT_W+FRAC_W)-1:0] dur_i,
   output logic [NUM_PHASES-1:0]                 sw_o,
   output logic                                  cycle_start_o
);
   localparam int DUR_W = INT_W + FRAC_W;
   localparam int CNT_W = INT_W + 1;
   localparam int IDX_W = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1;

   generate
      if (NUM_PHASES < 2) begin : g_bad_phases
         $error("NUM_PHASES must be at least 2");
      end
      if (INT_W < 1 || FRAC_W < 1) begin : g_bad_widths
         $error("INT_W and FRAC_W must be positive");
      end
   endgenerate

   logic [NUM_PHASES-1:0][CNT_W-1:0] eff_new, eff_q;
   logic [NUM_PHASES-1:0]            mask_new, mask_q;
   logic                             act_q, act_d;
   logic [IDX_W-1:0]                 ph_q, ph_d;
   logic [CNT_W-1:0]                 cnt_q, load_val;
   logic                             load, start_cycle;
   logic                             nxt_found, fst_found;
   logic [IDX_W-1:0]                 nxt_idx, fst_idx;
   logic [NUM_PHASES-1:0]            sw_d;
   logic                             rst_seen_q;

   for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
      qpd_frac_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
         .clk    (clk),
         .rst    (rst),
         .step_i (start_cycle),
         .int_i  (dur_i[p*DUR_W+FRAC_W +: INT_W]),
         .frac_i (dur_i[p*DUR_W +: FRAC_W]),
         .eff_o  (eff_new[p])
      );
      assign mask_new[p] = (eff_new[p] != '0);
      assign mask_q[p]   = (eff_q[p] != '0);
   end

   qpd_phase_pick #(.NUM_PHASES(NUM_PHASES), .IDX_W(IDX_W)) u_pick_next (
      .mask_i  (mask_q),
      .start_i ({1'b0, ph_q} + (IDX_W+1)'(1)),
      .found_o (nxt_found),
      .idx_o   (nxt_idx)
   );

   qpd_phase_pick #(.NUM_PHASES(NUM_PHASES), .IDX_W(IDX_W)) u_pick_first (
      .mask_i  (mask_new),
      .start_i ('0),
      .found_o (fst_found),
      .idx_o   (fst_idx)
   );

   qpd_down_cnt #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .load_i (load),
      .val_i  (load_val),
      .cnt_o  (cnt_q)
   );

   always_comb begin
      act_d       = act_q;
      ph_d        = ph_q;
      load        = 1'b0;
      load_val    = '0;
      start_cycle = 1'b0;
      if (act_q && cnt_q != '0) begin
         act_d = 1'b1;
      end else if (act_q && nxt_found) begin
         ph_d     = nxt_idx;
         load     = 1'b1;
         load_val = eff_q[nxt_idx] - CNT_W'(1);
      end else if (run_en) begin
         start_cycle = 1'b1;
         act_d       = fst_found;
         ph_d        = fst_idx;
         load        = 1'b1;
         load_val    = fst_found ? (eff_new[fst_idx] - CNT_W'(1)) : '0;
      end else begin
         act_d = 1'b0;
         load  = 1'b1;
      end
      sw_d = '0;
      if (act_d) sw_d[ph_d] = 1'b1;
   end

   always_ff @(posedge clk) begin
      rst_seen_q <= rst;
      if (rst) begin
         act_q         <= 1'b0;
         ph_q          <= '0;
         eff_q         <= '0;
         sw_o          <= '0;
         cycle_start_o <= 1'b0;
      end else begin
         act_q         <= act_d;
         ph_q          <= ph_d;
         sw_o          <= sw_d;
         cycle_start_o <= start_cycle;
         if (start_cycle) eff_q <= eff_new;
      end
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst_seen_q |-> (sw_o == '0 && !cycle_start_o));
   // R2
   single_switch_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sw_o));
   // R3
   phase_order_chk: assert property (@(posedge clk) disable iff (rst)
      (act_q && $past(act_q) && !cycle_start_o && ph_q != $past(ph_q)) |-> (ph_q > $past(ph_q)));
   // R5
   sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !cycle_start_o |-> $stable(eff_q));
   // R6
   start_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
      cycle_start_o |-> $past(!act_q || cnt_q == '0));
   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (!act_q && !run_en) |=> (sw_o == '0 && !cycle_start_o));
endmodule

// File: tb/quad_phase_dither_seq_bench.sv
module quad_phase_dither_seq_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        run_en = 1'b0;
   logic [71:0] dur = '0;
   logic [3:0]  sw_o;
   logic        cycle_start_o;

   int checks = 0, errs = 0, cyc = 0;
   bit cmp_on = 0;

   always #10 clk = ~clk;

   quad_phase_dither_seq u_quad_phase_dither_seq (
      .clk(clk), .rst(rst), .run_en(run_en), .dur_i(dur),
      .sw_o(sw_o), .cycle_start_o(cycle_start_o));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // reference model: queue of pending (phase,length) pairs per cycle
   int m_acc[4];
   int q_ph[$], q_len[$];
   int m_left = 0, m_ph = 0;
   bit exp_cs = 0;
   logic [3:0] exp_sw = '0;

   always @(posedge clk) begin
      exp_cs = 0;
      if (rst) begin
         for (int p = 0; p < 4; p++) m_acc[p] = 0;
         q_ph.delete(); q_len.delete();
         m_left = 0;
      end else if (m_left > 1) begin
         m_left--;
      end else if (q_ph.size() > 0) begin
         m_ph = q_ph.pop_front();
         m_left = q_len.pop_front();
      end else if (run_en) begin
         exp_cs = 1;
         for (int p = 0; p < 4; p++) begin
            int ip, fp, s, len;
            ip = int'(dur[p*18+10 +: 8]);
            fp = int'(dur[p*18 +: 10]);
            s = m_acc[p] + fp;
            len = ip + ((s >= 1024) ? 1 : 0);
            m_acc[p] = s % 1024;
            if (len > 0) begin q_ph.push_back(p); q_len.push_back(len); end
         end
         if (q_ph.size() > 0) begin
            m_ph = q_ph.pop_front();
            m_left = q_len.pop_front();
         end else m_left = 0;
      end else begin
         m_left = 0;
      end
      exp_sw = (m_left > 0) ? 4'(1 << m_ph) : 4'b0;
   end

   // pulse monitor and per-clock comparison
   int run_n[4], hi_clk[4];
   int pq_ph[$], pq_len[$];

   always @(negedge clk) begin
      if (cmp_on) begin
         chk(sw_o === exp_sw, "R3 switch outputs vs model", int'(sw_o), int'(exp_sw));
         chk(cycle_start_o === exp_cs, "R6 cycle_start vs model", int'(cycle_start_o), int'(exp_cs));
      end
      if (cycle_start_o) begin
         for (int p = 0; p < 4; p++)
            if (run_n[p] > 0) begin pq_ph.push_back(p); pq_len.push_back(run_n[p]); run_n[p] = 0; end
      end
      for (int p = 0; p < 4; p++) begin
         if (sw_o[p] === 1'b1) begin run_n[p]++; hi_clk[p]++; end
         else if (run_n[p] > 0) begin pq_ph.push_back(p); pq_len.push_back(run_n[p]); run_n[p] = 0; end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errs++; checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #5; end
   endtask

   task automatic set_dur(input int p, input int ip, input int fp);
      dur[p*18 +: 18] = {8'(ip), 10'(fp)};
   endtask

   task automatic clear_mon();
      pq_ph.delete(); pq_len.delete();
      for (int p = 0; p < 4; p++) hi_clk[p] = 0;
   endtask

   task automatic do_reset();
      rst = 1'b1; run_en = 1'b0;
      step(3);
      rst = 1'b0;
      step(1);
   endtask

   // run until n cycle starts seen, then drop run_en and wait for idle
   task automatic run_cycles(input int n);
      int seen = 0;
      run_en = 1'b1;
      while (seen < n) begin
         step(1);
         if (cycle_start_o) seen++;
      end
      run_en = 1'b0;
      step(600);
   endtask

   initial begin
      int idx, e_ph, e_len, nrand;
      for (int p = 0; p < 4; p++) begin run_n[p] = 0; hi_clk[p] = 0; end
      step(1);
      cmp_on = 1;
      step(2);
      // R1 reset state
      chk(sw_o == 4'b0, "R1 switches low in reset", int'(sw_o), 0);
      chk(cycle_start_o == 1'b0, "R1 cycle_start low in reset", int'(cycle_start_o), 0);
      rst = 1'b0;
      step(4);
      chk(sw_o == 4'b0, "R8 idle without run_en", int'(sw_o), 0);

      // R4/R3: fractional dithering per phase
      set_dur(0, 3, 0); set_dur(1, 2, 512); set_dur(2, 1, 0); set_dur(3, 4, 256);
      clear_mon();
      run_cycles(4);
      chk(pq_ph.size() == 16, "R4 pulse count", pq_ph.size(), 16);
      for (int c = 0; c < 4; c++)
         for (int p = 0; p < 4; p++) begin
            idx = c*4 + p;
            e_len = (p == 0) ? 3 : (p == 1) ? 2 + (c % 2) : (p == 2) ? 1 : ((c == 3) ? 5 : 4);
            if (idx < pq_ph.size()) begin
               chk(pq_ph[idx] == p, "R3 phase order", pq_ph[idx], p);
               chk(pq_len[idx] == e_len, "R4 dithered length", pq_len[idx], e_len);
            end
         end
      chk(sw_o == 4'b0, "R8 idle after finishing last cycle", int'(sw_o), 0);

      // R7: zero-length phases skipped; fractional-only phase appears every other cycle
      set_dur(0, 2, 0); set_dur(1, 0, 0); set_dur(2, 0, 512); set_dur(3, 2, 0);
      clear_mon();
      run_cycles(2);
      chk(hi_clk[1] == 0, "R7 zero phase never asserted", hi_clk[1], 0);
      chk(pq_ph.size() == 5, "R7 pulse count", pq_ph.size(), 5);
      for (int k = 0; k < 5 && k < pq_ph.size(); k++) begin
         e_ph  = (k == 0 || k == 2) ? 0 : (k == 3) ? 2 : 3;
         e_len = (k == 3) ? 1 : 2;
         chk(pq_ph[k] == e_ph, "R7 phase sequence", pq_ph[k], e_ph);
         chk(pq_len[k] == e_len, "R7 phase length", pq_len[k], e_len);
      end

      // R5: mid-cycle change ignored
      for (int p = 0; p < 4; p++) set_dur(p, 5, 0);
      clear_mon();
      run_en = 1'b1;
      do step(1); while (!cycle_start_o);
      run_en = 1'b0;
      for (int p = 0; p < 4; p++) set_dur(p, 1, 0);
      step(60);
      for (int p = 0; p < 4; p++)
         chk(hi_clk[p] == 5, "R5 length held through cycle", hi_clk[p], 5);

      // R8: start from phase 0 and a single cycle only
      chk(pq_ph.size() > 0 && pq_ph[0] == 0, "R8 first phase is 0", pq_ph.size() > 0 ? pq_ph[0] : -1, 0);

      // R9: long-run mean of 13 + 742/1024
      do_reset();
      set_dur(0, 13, 742); set_dur(1, 1, 0); set_dur(2, 1, 0); set_dur(3, 1, 0);
      clear_mon();
      run_cycles(512);
      chk(hi_clk[0] == 512*13 + 371, "R9 average high time", hi_clk[0], 512*13 + 371);
      chk(hi_clk[1] == 512, "R9 integer phase total", hi_clk[1], 512);

      // randomised lengths, changed every cycle, checked by the model
      run_en = 1'b1;
      nrand = 0;
      while (nrand < 40) begin
         step(1);
         if (cycle_start_o) begin
            nrand++;
            for (int p = 0; p < 4; p++) set_dur(p, $urandom_range(0, 6), $urandom_range(0, 1023));
         end
      end
      run_en = 1'b0;
      step(100);
      chk(sw_o == 4'b0, "R8 idle after random run", int'(sw_o), 0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule